// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Vector Controller

This block arbitrates the eight interrupt sources of a two-channel serial controller and supplies the vector that the host reads when it services them. Each channel (A and B) raises four kinds of request: transmit buffer empty, external/status change, receive character available and special receive condition. A request pulse on a channel that is armed latches a pending flag. A fixed priority picks the winner. An acknowledge strobe moves the winner into service, and an end-of-interrupt strobe retires the highest request in service. The block drives an enable output for an interrupt daisy chain from the enable input it receives from the device ahead of it.

An 8-bit command register write controls the block. Bits 7:6 hold a reset action. Bit 5 selects no-acknowledge mode, bit 4 selects where the status code goes in the vector, bit 3 is the master enable, bit 2 is a loop control flag that passes through to the channel logic, and bits 1 (channel A) and 0 (channel B) arm a channel's interrupts when written as 1. Both the vector captured on acknowledge and a continuously readable status vector carry a 3-bit source code merged into a caller-supplied base vector.

Top module: `sio_irq_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, master enable, status-high select, no-acknowledge mode, loop control, both channel arms, every pending and in-service flag, `ack_vec` and `chan_clr` are zero, and `wr_busy` and `irq` are low.
- R2: An accepted write with bits 7:6 = 00 loads no-ack mode from bit 5, status-high from bit 4, master enable from bit 3 and `loop_ctl` from bit 2. A 1 in bit 1 arms channel A and a 1 in bit 0 arms channel B, and a 0 in either leaves that arm unchanged. A request pulse on a channel that is not armed is dropped.
- R3: An accepted write with bits 7:6 = 01 clears every pending and in-service flag of channel B (codes 0 to 3) and disarms channel B, and `chan_clr` is 2'b01 for the next cycle. Channel A is left as it is.
- R4: An accepted write with bits 7:6 = 10 does the same for channel A (codes 4 to 7), with `chan_clr` 2'b10.
- R5: An accepted write with bits 7:6 = 11 clears all flags, both arms and no-ack mode, and sets `chan_clr` to 2'b11. Master enable, status-high and loop control still take bits 3, 4 and 2 of the same write.
- R6: After an accepted write with a nonzero reset action, `wr_busy` is high for exactly BUSY_CYC cycles, and writes in those cycles are ignored.
- R7: Source codes are 0 B transmit empty, 1 B external/status, 2 B receive available, 3 B special receive, 4 to 7 the same for channel A. The priority order is A special, A receive, A transmit, A external, B special, B receive, B transmit, B external.
- R8: `vec_b` equals `vec_base` with the code of the highest pending source (3'b011 when nothing is pending) merged in. When status-high is 0, code bits 2,1,0 go to vector bits 3,2,1. When status-high is 1, they go to vector bits 4,5,6.
- R9: An acknowledge taken while `irq` is high and no-ack mode is off sets the in-service flag of the winning source, clears its pending flag and loads `ack_vec` with the `vec_b` value of that cycle.
- R10: An `eoi` pulse clears the highest-priority in-service flag.
- R11: `ien_out` is low while any in-service flag is set. With master enable off and nothing in service, `ien_out` follows `ien_in`.
- R12: With master enable off, no in-service flag becomes set and `irq` is low.
- R13: In no-ack mode the acknowledge strobe has no effect, and `ien_out` is low whenever master enable is on and anything is pending.
- R14: `irq` is high exactly when master enable and `ien_in` are high and the top pending source outranks every in-service source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 8 | Command register write data |
| wr_busy | output | 1 | Writes refused after a reset action |
| ack | input | 1 | Interrupt acknowledge strobe |
| eoi | input | 1 | Retire the highest in-service source |
| src_req | input | 8 | Request pulses, indexed by source code |
| vec_base | input | 8 | Base vector that the status code is merged into |
| ien_in | input | 1 | Daisy-chain enable from the device ahead |
| ien_out | output | 1 | Daisy-chain enable to the device behind |
| irq | output | 1 | Interrupt request |
| vec_b | output | 8 | Live status vector |
| ack_vec | output | 8 | Vector captured on the last taken acknowledge |
| chan_clr | output | 2 | One-cycle channel reset pulse, bit 1 A, bit 0 B |
| loop_ctl | output | 1 | Loop control flag |

## Verification
The bench builds the block with BUSY_CYC at its default of 5. At that value the full refusal window of a reset action is short enough to cover: the bench writes through every busy cycle and then checks the first write that is accepted. Directed steps walk the priority order across both channels and the mirrored status placement, and test nested acknowledges against end-of-interrupt. A long random run mixes writes, acknowledges and sparse requests so that channel resets land on flags that are in service and on writes that are still pending.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NSRC    = 8;
  localparam int NCH     = 2;
  localparam int SPC     = NSRC / NCH;
  localparam int CODE_W  = 3;
  localparam int VEC_W   = 8;
  localparam int LO_POS  = 1;
  localparam int HI_POS  = 4;
  localparam logic [CODE_W-1:0] IDLE_CODE = 3'b011;

  typedef enum logic [1:0] {
    RC_NONE = 2'b00,
    RC_CH_B = 2'b01,
    RC_CH_A = 2'b10,
    RC_FULL = 2'b11
  } rst_cmd_e;

  typedef struct packed {
    logic noack;
    logic stat_hi;
    logic mie;
    logic loop;
  } mode_t;

  // Rank: channel A above B; within a channel special > receive > transmit > external.
  function automatic logic [2:0] src_rank(logic [CODE_W-1:0] c);
    logic [1:0] w;
    case (c[1:0])
      2'b11:   w = 2'd3;
      2'b10:   w = 2'd2;
      2'b00:   w = 2'd1;
      default: w = 2'd0;
    endcase
    return {c[2], w};
  endfunction
endpackage

// File: rtl/sio_prio_pick.sv
module sio_prio_pick
  import sio_irq_pkg::*;
(
  input  logic [NSRC-1:0]   req,
  output logic              vld,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    vld  = 1'b0;
    code = IDLE_CODE;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (!vld || (src_rank(CODE_W'(i)) > src_rank(code)))) begin
        vld  = 1'b1;
        code = CODE_W'(i);
      end
    end
  end
endmodule

// File: rtl/sio_cmd_reg.sv
module sio_cmd_reg
  import sio_irq_pkg::*;
#(
  parameter int BUSY_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VEC_W-1:0] wr_data,
  output logic             wr_acc,
  output mode_t            mode,
  output logic [NCH-1:0]   chan_en,
  output logic [NCH-1:0]   clr_now,
  output logic [NCH-1:0]   chan_clr,
  output logic             wr_busy
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);

  rst_cmd_e         rc;
  mode_t            mode_q, mode_n;
  logic [NCH-1:0]   en_q, en_n;
  logic [NCH-1:0]   clr_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign wr_busy = (cnt_q != '0);
  assign wr_acc  = wr_en && !wr_busy;
  assign rc      = rst_cmd_e'(wr_data[7:6]);

  always_comb begin
    clr_now = '0;
    if (wr_acc) begin
      case (rc)
        RC_CH_B: clr_now = 2'b01;
        RC_CH_A: clr_now = 2'b10;
        RC_FULL: clr_now = 2'b11;
        default: clr_now = 2'b00;
      endcase
    end
  end

  always_comb begin
    mode_n = mode_q;
    en_n   = en_q;
    if (wr_acc) begin
      mode_n.noack   = (rc == RC_FULL) ? 1'b0 : wr_data[5];
      mode_n.stat_hi = wr_data[4];
      mode_n.mie     = wr_data[3];
      mode_n.loop    = wr_data[2];
      en_n = (en_q | ((rc == RC_FULL) ? 2'b00 : wr_data[1:0])) & ~clr_now;
    end
  end

  always_comb begin
    if (wr_acc && (rc != RC_NONE)) cnt_n = CNT_LOAD;
    else if (cnt_q != '0)          cnt_n = cnt_q - 1'b1;
    else                           cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= '0;
      clr_q  <= '0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_n;
      en_q   <= en_n;
      clr_q  <= clr_now;
      cnt_q  <= cnt_n;
    end
  end

  assign mode     = mode_q;
  assign chan_en  = en_q;
  assign chan_clr = clr_q;
endmodule

// File: rtl/sio_src_track.sv
module sio_src_track
  import sio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic [NCH-1:0]    chan_en,
  input  logic [NCH-1:0]    clr_now,
  input  logic              mie,
  input  logic              noack,
  input  logic              ien_in,
  input  logic              ack,
  input  logic              eoi,
  output logic [NSRC-1:0]   isv,
  output logic              irq,
  output logic              top_vld,
  output logic [CODE_W-1:0] top_code,
  output logic              ack_take
);
  logic [NSRC-1:0]   pend_q, pend_n, isv_q, isv_n;
  logic [NSRC-1:0]   en_mask, rst_mask, ack_bit, eoi_bit;
  logic              s_vld;
  logic [CODE_W-1:0] s_code;
  logic              outranks;

  sio_prio_pick u_pend_pick (.req(pend_q), .vld(top_vld), .code(top_code));
  sio_prio_pick u_isv_pick  (.req(isv_q),  .vld(s_vld),   .code(s_code));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign en_mask [ch*SPC +: SPC] = {SPC{chan_en[ch]}};
    assign rst_mask[ch*SPC +: SPC] = {SPC{clr_now[ch]}};
  end

  assign outranks = top_vld && (!s_vld || (src_rank(top_code) > src_rank(s_code)));
  assign irq      = mie && ien_in && outranks;
  assign ack_take = ack && !noack && irq;
  assign ack_bit  = ack_take ? (NSRC'(1) << top_code) : '0;
  assign eoi_bit  = (eoi && s_vld) ? (NSRC'(1) << s_code) : '0;

  always_comb begin
    pend_n = ((pend_q & ~ack_bit) | (src_req & en_mask)) & ~rst_mask;
    isv_n  = ((isv_q & ~eoi_bit) | ack_bit) & ~rst_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      isv_q  <= '0;
    end else begin
      pend_q <= pend_n;
      isv_q  <= isv_n;
    end
  end

  assign isv = isv_q;
endmodule

// File: rtl/sio_vec_fmt.sv
module sio_vec_fmt
  import sio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  vec_base,
  input  logic              stat_hi,
  input  logic              code_vld,
  input  logic [CODE_W-1:0] code,
  input  logic              ack_take,
  output logic [VEC_W-1:0]  vec_b,
  output logic [VEC_W-1:0]  ack_vec
);
  logic [CODE_W-1:0] sel;
  logic [VEC_W-1:0]  hold_q, hold_n;

  assign sel = code_vld ? code : IDLE_CODE;

  always_comb begin
    vec_b = vec_base;
    for (int i = 0; i < CODE_W; i++) begin
      if (stat_hi) vec_b[HI_POS + i] = sel[CODE_W - 1 - i];
      else         vec_b[LO_POS + i] = sel[i];
    end
  end

  assign hold_n = ack_take ? vec_b : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_n;
  end

  assign ack_vec = hold_q;
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int BUSY_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VEC_W-1:0] wr_data,
  output logic             wr_busy,
  input  logic             ack,
  input  logic             eoi,
  input  logic [NSRC-1:0]  src_req,
  input  logic [VEC_W-1:0] vec_base,
  input  logic             ien_in,
  output logic             ien_out,
  output logic             irq,
  output logic [VEC_W-1:0] vec_b,
  output logic [VEC_W-1:0] ack_vec,
  output logic [NCH-1:0]   chan_clr,
  output logic             loop_ctl
);
  mode_t             mode;
  logic              wr_acc;
  logic [NCH-1:0]    chan_en, clr_now;
  logic [NSRC-1:0]   isv;
  logic              top_vld, ack_take;
  logic [CODE_W-1:0] top_code;
  logic              mie_w, noack_w;

  sio_cmd_reg #(.BUSY_CYC(BUSY_CYC)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_acc(wr_acc), .mode(mode), .chan_en(chan_en), .clr_now(clr_now),
    .chan_clr(chan_clr), .wr_busy(wr_busy)
  );

  assign mie_w   = mode.mie;
  assign noack_w = mode.noack;

  sio_src_track u_trk (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .chan_en(chan_en),
    .clr_now(clr_now), .mie(mie_w), .noack(noack_w), .ien_in(ien_in),
    .ack(ack), .eoi(eoi), .isv(isv), .irq(irq), .top_vld(top_vld),
    .top_code(top_code), .ack_take(ack_take)
  );

  sio_vec_fmt u_vec (
    .clk(clk), .rst_n(rst_n), .vec_base(vec_base), .stat_hi(mode.stat_hi),
    .code_vld(top_vld), .code(top_code), .ack_take(ack_take),
    .vec_b(vec_b), .ack_vec(ack_vec)
  );

  assign ien_out  = ien_in && (isv == '0) && !(mie_w && noack_w && top_vld);
  assign loop_ctl = mode.loop;
endmodule

// File: rtl/sio_irq_chk.sv
module sio_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_acc,
  input logic [1:0] wr_rc,
  input logic       wr_busy,
  input logic       mie,
  input logic       noack,
  input logic [7:0] isv,
  input logic       ien_in,
  input logic       ien_out,
  input logic       irq,
  input logic [1:0] chan_clr
);
  a_r3_chan_b_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && wr_rc == 2'b01) |=> (isv[3:0] == 4'h0 && chan_clr == 2'b01));

  a_r4_chan_a_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && wr_rc == 2'b10) |=> (isv[7:4] == 4'h0 && chan_clr == 2'b10));

  a_r5_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && wr_rc == 2'b11) |=> (isv == 8'h00 && chan_clr == 2'b11 && !noack));

  a_r6_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && wr_rc != 2'b00) |=> wr_busy);

  a_r11_chain_low: assert property (@(posedge clk) disable iff (!rst_n)
    (isv != 8'h00) |-> !ien_out);

  a_r11_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!mie && isv == 8'h00) |-> (ien_out == ien_in));

  a_r12_no_isv_set: assert property (@(posedge clk) disable iff (!rst_n)
    !mie |=> ($countones(isv) <= $past($countones(isv))));

  a_r13_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    noack |=> ((isv & ~$past(isv)) == 8'h00));

  a_r14_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mie && ien_in));
endmodule

bind sio_irq_ctrl sio_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_rc(wr_data[7:6]),
  .wr_busy(wr_busy), .mie(mie_w), .noack(noack_w), .isv(isv),
  .ien_in(ien_in), .ien_out(ien_out), .irq(irq), .chan_clr(chan_clr)
);

// File: tb/sim_sio_irq_ctrl.sv
module sim_sio_irq_ctrl;
  logic       clk, rst_n;
  logic       wr_en, ack, eoi, ien_in;
  logic [7:0] wr_data, src_req, vec_base;
  logic       wr_busy, ien_out, irq, loop_ctl;
  logic [7:0] vec_b, ack_vec;
  logic [1:0] chan_clr;

  int n_chk = 0;
  int n_bad = 0;

  // bench-side model state
  logic [7:0] m_pend, m_isv, m_ackvec;
  logic [1:0] m_en, m_clr;
  logic       m_mie, m_sh, m_noack, m_loop;
  int         m_busy;

  sio_irq_ctrl #(.BUSY_CYC(5)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_busy(wr_busy),
    .ack(ack), .eoi(eoi), .src_req(src_req), .vec_base(vec_base), .ien_in(ien_in),
    .ien_out(ien_out), .irq(irq), .vec_b(vec_b), .ack_vec(ack_vec),
    .chan_clr(chan_clr), .loop_ctl(loop_ctl)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // R7 ranking
  function automatic logic [2:0] rk(logic [2:0] c);
    logic [1:0] w;
    case (c[1:0])
      2'b11: w = 2'd3;
      2'b10: w = 2'd2;
      2'b00: w = 2'd1;
      default: w = 2'd0;
    endcase
    return {c[2], w};
  endfunction

  function automatic void pick(input logic [7:0] m, output logic v, output logic [2:0] c);
    v = 1'b0; c = 3'b011;
    for (int i = 0; i < 8; i++)
      if (m[i] && (!v || rk(3'(i)) > rk(c))) begin v = 1'b1; c = 3'(i); end
  endfunction

  // R8 placement
  function automatic logic [7:0] place(logic [7:0] b, logic sh, logic [2:0] c);
    logic [7:0] v = b;
    if (sh) begin v[4] = c[2]; v[5] = c[1]; v[6] = c[0]; end
    else v[3:1] = c;
    return v;
  endfunction

  task automatic model_reset();
    m_pend = '0; m_isv = '0; m_ackvec = '0; m_en = '0; m_clr = '0;
    m_mie = 0; m_sh = 0; m_noack = 0; m_loop = 0; m_busy = 0;
  endtask

  // drive inputs, compare outputs, advance model, cross one clock edge
  task automatic step(logic w, logic [7:0] d, logic a, logic e, logic [7:0] r);
    logic pv, sv, outr, e_irq, e_ien, acc;
    logic [2:0] pc, sc;
    logic [7:0] e_vec, ackm, eoim, enm, np, ni, rm;
    logic [1:0] clrm;
    wr_en = w; wr_data = d; ack = a; eoi = e; src_req = r;
    #1;
    pick(m_pend, pv, pc);
    pick(m_isv, sv, sc);
    outr  = pv && (!sv || rk(pc) > rk(sc));
    e_irq = m_mie && ien_in && outr;
    e_ien = ien_in && (m_isv == 0) && !(m_mie && m_noack && pv);
    e_vec = place(vec_base, m_sh, pv ? pc : 3'b011);
    chk("R14 irq", {7'b0, irq}, {7'b0, e_irq});
    chk("R11 ien_out", {7'b0, ien_out}, {7'b0, e_ien});
    chk("R8 vec_b", vec_b, e_vec);
    chk("R9 ack_vec", ack_vec, m_ackvec);
    chk("R6 wr_busy", {7'b0, wr_busy}, {7'b0, m_busy != 0});
    chk("R3 R4 chan_clr", {6'b0, chan_clr}, {6'b0, m_clr});
    chk("R2 loop_ctl", {7'b0, loop_ctl}, {7'b0, m_loop});
    acc  = w && (m_busy == 0);
    ackm = (a && !m_noack && e_irq) ? (8'(1) << pc) : 8'h00;
    eoim = (e && sv) ? (8'(1) << sc) : 8'h00;
    enm  = {{4{m_en[1]}}, {4{m_en[0]}}};
    np   = (m_pend & ~ackm) | (r & enm);
    ni   = (m_isv & ~eoim) | ackm;
    if (ackm != 0) m_ackvec = e_vec;
    clrm = acc ? d[7:6] : 2'b00;
    if (acc) begin
      m_noack = (d[7:6] == 2'b11) ? 1'b0 : d[5];
      m_sh = d[4]; m_mie = d[3]; m_loop = d[2];
      m_en = (m_en | ((d[7:6] == 2'b11) ? 2'b00 : d[1:0])) & ~clrm;
    end
    rm = {{4{clrm[1]}}, {4{clrm[0]}}};
    m_pend = np & ~rm;
    m_isv  = ni & ~rm;
    m_clr  = clrm;
    m_busy = (acc && d[7:6] != 2'b00) ? 5 : ((m_busy > 0) ? m_busy - 1 : 0);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 8'h00);
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17_C3E1));
    rst_n = 0; wr_en = 0; wr_data = 0; ack = 0; eoi = 0; src_req = 0;
    vec_base = 8'h00; ien_in = 1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 vec_b idle", vec_b, 8'h06);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 ien_out", {7'b0, ien_out}, 8'h01);
    chk("R1 busy", {7'b0, wr_busy}, 8'h00);
    chk("R1 ack_vec", ack_vec, 8'h00);
    @(negedge clk);

    step(1, 8'h0B, 0, 0, 8'h00);            // R2 mie on, arm both
    step(0, 8'h00, 0, 0, 8'h03); idle(1);
    chk("R7 B tx over B ext", vec_b, 8'h00);
    chk("R2 irq after arm", {7'b0, irq}, 8'h01);
    step(0, 8'h00, 0, 0, 8'h20); idle(1);
    chk("R7 A ext over B", vec_b, 8'h0A);
    step(0, 8'h00, 0, 0, 8'h10); idle(1);
    chk("R7 A tx over A ext", vec_b, 8'h08);
    step(1, 8'h1B, 0, 0, 8'h00); idle(1);
    chk("R8 mirrored code", vec_b, 8'h10);
    step(0, 8'h00, 1, 0, 8'h00); idle(1);
    chk("R9 ack_vec", ack_vec, 8'h10);
    chk("R11 chain low", {7'b0, ien_out}, 8'h00);
    chk("R14 lower not raised", {7'b0, irq}, 8'h00);
    chk("R9 next top", vec_b, 8'h50);
    step(0, 8'h00, 0, 0, 8'h80); idle(1);
    chk("R14 higher raises", {7'b0, irq}, 8'h01);
    step(0, 8'h00, 1, 0, 8'h00); idle(1);
    chk("R9 nested ack", ack_vec, 8'h70);
    step(0, 8'h00, 0, 1, 8'h00); idle(1);
    chk("R10 first eoi", {7'b0, irq}, 8'h00);
    step(0, 8'h00, 0, 1, 8'h00); idle(1);
    chk("R10 second eoi irq", {7'b0, irq}, 8'h01);
    chk("R10 second eoi chain", {7'b0, ien_out}, 8'h01);

    step(1, 8'h9B, 0, 0, 8'h00);            // R4 reset channel A
    chk("R4 chan_clr", {6'b0, chan_clr}, 8'h02);
    chk("R6 busy", {7'b0, wr_busy}, 8'h01);
    for (int i = 0; i < 5; i++) step(1, 8'h03, 0, 0, 8'h00);
    chk("R6 busy over", {7'b0, wr_busy}, 8'h00);
    chk("R6 write ignored", {7'b0, irq}, 8'h01);

    step(1, 8'h5B, 0, 0, 8'h00);            // R3 reset channel B
    chk("R3 chan_clr", {6'b0, chan_clr}, 8'h01);
    chk("R3 pending gone", {7'b0, irq}, 8'h00);
    idle(6);
    step(0, 8'h00, 0, 0, 8'h01); idle(1);
    chk("R3 B disarmed", {7'b0, irq}, 8'h00);
    step(0, 8'h00, 0, 0, 8'h10); idle(1);
    chk("R3 A untouched", {7'b0, irq}, 8'h01);

    step(1, 8'h2B, 0, 0, 8'h00); idle(1);   // R13 no-ack
    chk("R13 chain low", {7'b0, ien_out}, 8'h00);
    step(0, 8'h00, 1, 0, 8'h00); idle(1);
    chk("R13 ack ignored", ack_vec, 8'h70);

    step(1, 8'h03, 0, 0, 8'h00); idle(1);   // R12 mie off
    chk("R12 irq", {7'b0, irq}, 8'h00);
    step(0, 8'h00, 1, 0, 8'h00); idle(1);
    chk("R12 no ack", ack_vec, 8'h70);
    ien_in = 0; idle(1);
    chk("R11 follows", {7'b0, ien_out}, 8'h00);
    ien_in = 1;

    step(1, 8'hFC, 0, 0, 8'h00);            // R5 full reset command
    chk("R5 chan_clr", {6'b0, chan_clr}, 8'h03);
    chk("R5 loop", {7'b0, loop_ctl}, 8'h01);
    chk("R5 irq", {7'b0, irq}, 8'h00);
    idle(6);

    for (int n = 0; n < 4000; n++) begin
      logic w, a, e;
      logic [7:0] d, r;
      w = ($urandom % 8) == 0;
      d = 8'($urandom);
      if (($urandom % 10) != 0) d[7:6] = 2'b00;
      d[3] = ($urandom % 5) != 0;
      if (($urandom % 4) != 0) d[5] = 1'b0;
      a = ($urandom % 4) == 0;
      e = ($urandom % 6) == 0;
      r = 8'($urandom & $urandom & $urandom);
      ien_in = ($urandom % 10) != 0;
      if (($urandom % 50) == 0) vec_base = 8'($urandom);
      step(w, d, a, e, r);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule